// File: doc/BRIEF.md
# Status Flags and Branch Evaluator

This block sits next to a small 8-bit datapath. It turns each ALU result into four condition flags: negative, overflow, carry and zero. It holds those flags in a register that changes only when the flag-write enable is high.

Every cycle it also looks at the current opcode. If the opcode is a conditional branch, the block tests one stored flag against a polarity bit taken from the opcode. It then reports whether the branch is taken and presents the next program counter. The branch decision and the next PC are combinational. They use the flag register's current contents, so a branch sees the flags written on the clock edge before it.

Top module: `flag_branch_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all four stored flags. `flags_q` packs them as {negative, overflow, carry, zero}, bits 3 down to 0.
- R2: On a write, the stored negative flag takes bit 7 of `alu_res`.
- R3: On a write, the stored zero flag is 1 exactly when all eight bits of `alu_res` are 0.
- R4: On a write, the stored carry flag takes `alu_cout`.
- R5: On a write, the stored overflow flag is 1 when `opa_msb` equals the effective B sign and `alu_res[7]` differs from `opa_msb`. The effective B sign is `opb_msb` XOR `is_sub`.
- R6: With `flag_we` low and `rst` low, the stored flags keep their value across a clock edge, whatever the ALU inputs are.
- R7: An opcode counts as a branch only when its bits 4..0 equal 5'b10000. For any other opcode, `br_taken` is 0.
- R8: Opcode bits 7..6 select the flag that is tested: 00 = negative, 01 = overflow, 10 = carry, 11 = zero.
- R9: A branch is taken when the selected flag equals opcode bit 5, and not taken otherwise.
- R10: When the branch is taken, `pc_next` = `pc_in` + 2 + sign-extended `offset`, modulo 2^16.
- R11: When the branch is not taken, `pc_next` = `pc_in` + 2, modulo 2^16.
- R12: The branch decision uses the stored flags. A write takes effect for branch evaluation only after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flag_we | input | 1 | Flag register write enable |
| alu_res | input | 8 | ALU result |
| alu_cout | input | 1 | ALU carry-out |
| opa_msb | input | 1 | Sign bit of operand A |
| opb_msb | input | 1 | Sign bit of operand B as presented |
| is_sub | input | 1 | High when the ALU performed a subtraction |
| opcode | input | 8 | Current instruction opcode |
| pc_in | input | 16 | Address of the current instruction |
| offset | input | 8 | Signed branch displacement |
| flags_q | output | 4 | Stored flags {N, V, C, Z} |
| br_taken | output | 1 | Branch taken indication |
| pc_next | output | 16 | Next program counter |

## Verification
The assertions check on every cycle that reset clears the flags and that the flags hold while writes are disabled. They also check that the negative and zero flags follow the previous cycle's result on a write, that non-branch opcodes never report taken, and that the not-taken path always presents PC + 2. The overflow rule for addition versus subtraction, the flag-select encoding, the XNOR polarity and the wrap of the taken target are only shown by the bench's sweeps. Those sweeps cover every result value and sign combination, and every opcode against many stored flag patterns.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
    localparam int DATA_W    = 8;
    localparam int PC_W      = 16;
    localparam int INSTR_LEN = 2;
    localparam int SEL_W     = 2;

    typedef struct packed {
        logic n;
        logic v;
        logic c;
        logic z;
    } flags_t;

    typedef struct packed {
        flags_t flags;
    } fbu_state_t;

    localparam logic [4:0] BR_PATTERN = 5'b10000;
endpackage

// File: rtl/fbu_flag_gen.sv
module fbu_flag_gen
    import fbu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] res,
    input  logic         cout,
    input  logic         a_msb,
    input  logic         b_msb,
    input  logic         sub,
    output flags_t       flags
);
    logic b_eff;

    always_comb begin
        b_eff   = b_msb ^ sub;
        flags.n = res[W-1];
        flags.z = ~(|res);
        flags.c = cout;
        flags.v = (a_msb == b_eff) && (res[W-1] != a_msb);
    end
endmodule

// File: rtl/fbu_branch_eval.sv
module fbu_branch_eval
    import fbu_pkg::*;
(
    input  logic [7:0] opcode,
    input  flags_t     flags,
    output logic       taken
);
    logic       is_branch;
    logic       chosen;
    logic [SEL_W-1:0] sel;

    always_comb begin
        is_branch = (opcode[4:0] == BR_PATTERN);
        sel       = opcode[7:6];
        unique case (sel)
            2'b00:   chosen = flags.n;
            2'b01:   chosen = flags.v;
            2'b10:   chosen = flags.c;
            default: chosen = flags.z;
        endcase
        taken = is_branch && ~(chosen ^ opcode[5]);
    end
endmodule

// File: rtl/fbu_pc_target.sv
module fbu_pc_target
    import fbu_pkg::*;
#(
    parameter int PW = PC_W,
    parameter int OW = DATA_W,
    parameter int LEN = INSTR_LEN
) (
    input  logic [PW-1:0] pc,
    input  logic [OW-1:0] offset,
    input  logic          taken,
    output logic [PW-1:0] pc_next
);
    localparam logic [PW-1:0] STEP = PW'(LEN);

    logic [PW-1:0] seq_pc;
    logic [PW-1:0] off_ext;

    always_comb begin
        seq_pc  = pc + STEP;
        off_ext = {{(PW-OW){offset[OW-1]}}, offset};
        pc_next = taken ? (seq_pc + off_ext) : seq_pc;
    end
endmodule

// File: rtl/flag_branch_unit.sv
module flag_branch_unit
    import fbu_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         flag_we,
    input  logic [7:0]   alu_res,
    input  logic         alu_cout,
    input  logic         opa_msb,
    input  logic         opb_msb,
    input  logic         is_sub,
    input  logic [7:0]   opcode,
    input  logic [15:0]  pc_in,
    input  logic [7:0]   offset,
    output logic [3:0]   flags_q,
    output logic         br_taken,
    output logic [15:0]  pc_next
);
    fbu_state_t state_d, state_q;
    flags_t     fresh;
    logic       taken_w;

    fbu_flag_gen #(.W(DATA_W)) u_gen (
        .res   (alu_res),
        .cout  (alu_cout),
        .a_msb (opa_msb),
        .b_msb (opb_msb),
        .sub   (is_sub),
        .flags (fresh)
    );

    always_comb begin
        state_d = state_q;
        if (flag_we) begin
            state_d.flags = fresh;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    fbu_branch_eval u_br (
        .opcode (opcode),
        .flags  (state_q.flags),
        .taken  (taken_w)
    );

    fbu_pc_target #(.PW(PC_W), .OW(DATA_W), .LEN(INSTR_LEN)) u_pc (
        .pc      (pc_in),
        .offset  (offset),
        .taken   (taken_w),
        .pc_next (pc_next)
    );

    assign flags_q  = state_q.flags;
    assign br_taken = taken_w;
endmodule

// File: rtl/flag_branch_unit_chk.sv
module flag_branch_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        flag_we,
    input logic [7:0]  alu_res,
    input logic [7:0]  opcode,
    input logic [15:0] pc_in,
    input logic [3:0]  flags_q,
    input logic        br_taken,
    input logic [15:0] pc_next
);
    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (flags_q == 4'b0000));

    // R6
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> $stable(flags_q));

    // R2
    a_r2_negative: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> (flags_q[3] == $past(alu_res[7])));

    // R3
    a_r3_zero: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> (flags_q[0] == ($past(alu_res) == 8'h00)));

    // R7
    a_r7_not_branch: assert property (@(posedge clk) disable iff (rst)
        (opcode[4:0] != 5'b10000) |-> !br_taken);

    // R11
    a_r11_fallthrough: assert property (@(posedge clk) disable iff (rst)
        !br_taken |-> (pc_next == pc_in + 16'd2));
endmodule

bind flag_branch_unit flag_branch_unit_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .flag_we  (flag_we),
    .alu_res  (alu_res),
    .opcode   (opcode),
    .pc_in    (pc_in),
    .flags_q  (flags_q),
    .br_taken (br_taken),
    .pc_next  (pc_next)
);

// File: tb/flag_branch_unit_bench.sv
`timescale 1ns/1ps
module flag_branch_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        flag_we;
    logic [7:0]  alu_res;
    logic        alu_cout;
    logic        opa_msb;
    logic        opb_msb;
    logic        is_sub;
    logic [7:0]  opcode;
    logic [15:0] pc_in;
    logic [7:0]  offset;
    logic [3:0]  flags_q;
    logic        br_taken;
    logic [15:0] pc_next;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    flag_branch_unit u_flag_branch_unit (
        .clk(clk), .rst(rst), .flag_we(flag_we), .alu_res(alu_res),
        .alu_cout(alu_cout), .opa_msb(opa_msb), .opb_msb(opb_msb),
        .is_sub(is_sub), .opcode(opcode), .pc_in(pc_in), .offset(offset),
        .flags_q(flags_q), .br_taken(br_taken), .pc_next(pc_next)
    );

    function automatic logic [3:0] model_flags(logic [7:0] r, logic c,
                                               logic a, logic b, logic s);
        logic be;
        logic v;
        be = b ^ s;
        v  = ((a ^ r[7]) & (be ^ r[7]));
        return {r[7], v, c, (r == 8'd0)};
    endfunction

    function automatic logic model_taken(logic [7:0] op, logic [3:0] f);
        logic sel;
        if (op[4:0] != 5'b10000) return 1'b0;
        case (op[7:6])
            2'd0: sel = f[3];
            2'd1: sel = f[2];
            2'd2: sel = f[1];
            default: sel = f[0];
        endcase
        return (sel == op[5]);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_flags(logic [7:0] r, logic c, logic a, logic b, logic s);
        @(negedge clk);
        alu_res = r; alu_cout = c; opa_msb = a; opb_msb = b; is_sub = s;
        flag_we = 1'b1;
        @(negedge clk);
        flag_we = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] ef;
        rst = 1'b1; flag_we = 1'b0; alu_res = 8'hFF; alu_cout = 1'b1;
        opa_msb = 1'b0; opb_msb = 1'b0; is_sub = 1'b0;
        opcode = 8'h00; pc_in = 16'h1000; offset = 8'h00;
        @(negedge clk); @(negedge clk);
        check("R1 reset flags", flags_q, 4'h0);
        rst = 1'b0;

        // R2 R3 R4 R5: exhaustive flag generation
        for (int i = 0; i < 4096; i++) begin
            logic [7:0] r;
            logic c, a, b, s;
            r = i[7:0]; c = i[8]; a = i[9]; b = i[10]; s = i[11];
            write_flags(r, c, a, b, s);
            ef = model_flags(r, c, a, b, s);
            check("R2 negative", flags_q[3], ef[3]);
            check("R5 overflow", flags_q[2], ef[2]);
            check("R4 carry", flags_q[1], ef[1]);
            check("R3 zero", flags_q[0], ef[0]);
        end

        // R6: flags hold without write enable
        write_flags(8'h80, 1'b1, 1'b0, 1'b0, 1'b0);
        ef = flags_q;
        @(negedge clk);
        alu_res = 8'h00; alu_cout = 1'b0; opa_msb = 1'b1; opb_msb = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R6 hold", flags_q, ef);

        // R7 R8 R9 R10 R11: every opcode against many stored flag sets
        for (int k = 0; k < 32; k++) begin
            logic [7:0] r;
            case (k[1:0])
                2'd0: r = 8'h00;
                2'd1: r = 8'h01;
                2'd2: r = 8'h80;
                default: r = 8'h7F;
            endcase
            write_flags(r, k[2], k[3], k[4], 1'b0);
            ef = model_flags(r, k[2], k[3], k[4], 1'b0);
            for (int op = 0; op < 256; op++) begin
                logic t;
                logic [15:0] exp_pc;
                opcode = op[7:0];
                pc_in  = (k[0]) ? 16'hFFFE : 16'(16'h0100 * k + op);
                offset = (op[0]) ? 8'h80 : 8'h7F;
                #1;
                t = model_taken(opcode, ef);
                exp_pc = pc_in + 16'd2 + (t ? {{8{offset[7]}}, offset} : 16'd0);
                if (op[4:0] != 5'b10000)
                    check("R7 non-branch", br_taken, 1'b0);
                else
                    check("R8 R9 taken", br_taken, t);
                if (t) check("R10 taken target", pc_next, exp_pc);
                else   check("R11 fall-through", pc_next, exp_pc);
            end
        end

        // R12: a new flag value reaches the branch only after the edge
        write_flags(8'h01, 1'b0, 1'b0, 1'b0, 1'b0);   // Z=0
        opcode = 8'hF0;                                // zero flag, y=1
        @(negedge clk);
        alu_res = 8'h00; flag_we = 1'b1;
        #1;
        check("R12 before edge", br_taken, 1'b0);
        @(negedge clk);
        flag_we = 1'b0;
        check("R12 after edge", br_taken, 1'b1);

        // R1: reset after activity
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset again", flags_q, 4'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule